// File: doc/BRIEF.md
# Trigger Derandomizer Occupancy Mirror

This block keeps a shadow copy of the derandomizing event buffer inside a front-end readout chip. That chip holds up to 16 triggered events and ships them out one after another. The mirror runs on the 40 MHz bunch-crossing clock, with one clock edge per crossing. On every first-level accept it records a tag: the current bunch-crossing number, the running event number and the event type. The readout formatter reads the oldest tag and attaches it to the matching block of hit data, so every event leaving the board carries the right identifiers.

The mirror also paces the readout. While it holds at least one event and the link is idle, it sends a single-cycle start to the formatter. That transfer lasts 35 words: two header words, 32 hit words and one trailer word. The formatter reports the end of the transfer with a done pulse, and the mirror then drops the oldest tag.

An accept that arrives with all 16 slots taken cannot be held by the chip either. It is refused, and the refusal sets a sticky overflow flag. The event number still advances on a refused accept, so the tags of later events stay aligned with the chip's own count.

Top module: `trig_derand_mirror`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `occupancy_o` is 0, `overflow_o` is 0 and `fmt_start_o` is 0.
- R2: The 12-bit crossing number advances by one every clock cycle. In the cycle after it equals or exceeds `bc_last_i`, it is 0. In the cycle after `bc_clear_i` is high, it is 0.
- R3: The 24-bit event number advances by one for every cycle with `l1_accept_i` high, refused accepts included. `ec_clear_i` takes priority over an accept and makes the next value 0.
- R4: A stored tag holds the crossing number, event number and `evt_type_i` as they stood in the cycle of the accept, before that cycle's update. While `occupancy_o` is nonzero, `head_bc_o`, `head_ec_o` and `head_type_o` show the oldest stored tag.
- R5: `occupancy_o` rises by one for each stored accept and falls by one for each pop. When a store and a pop happen in the same cycle, it is unchanged.
- R6: An accept that arrives while `occupancy_o` is 16 is not stored, even if a pop happens in the same cycle. `overflow_o` is high from the next cycle until `rst_n` is asserted.
- R7: `fmt_start_o` is a one-cycle pulse. It appears in the cycle after one in which `occupancy_o` is nonzero and the link is idle. The link counts as busy from the start pulse up to and including the cycle in which `fmt_done_i` is sampled high.
- R8: `fmt_done_i` high while the link is busy pops the oldest tag. `fmt_done_i` high while the link is idle changes nothing.
- R9: Tags leave the mirror in the same order as their accepts arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l1_accept_i | input | 1 | First-level trigger accept for the current crossing |
| evt_type_i | input | 4 | Event type recorded with the accept |
| bc_clear_i | input | 1 | Clears the crossing number |
| ec_clear_i | input | 1 | Clears the event number |
| bc_last_i | input | 12 | Highest crossing number before the count wraps to 0 |
| fmt_done_i | input | 1 | Formatter has finished the 35-word transfer |
| fmt_start_o | output | 1 | Start pulse for the next event readout |
| head_bc_o | output | 12 | Crossing number of the oldest tag |
| head_ec_o | output | 24 | Event number of the oldest tag |
| head_type_o | output | 4 | Event type of the oldest tag |
| occupancy_o | output | 5 | Number of stored tags (0 to 16) |
| overflow_o | output | 1 | Sticky overflow flag |

## Verification
The embedded properties rely on two internal guarantees. A pop never reaches an empty store, because the sequencer only pops while a transfer is in flight, and a transfer only begins when the store holds a tag. The store is never pushed while full, because the top gates every accept with the full condition. At the block's ports the only assumption is that `fmt_done_i` may come at any time. The bench therefore injects stray done pulses only while its reference model shows the link idle, which is exactly the case R8 says must be ignored. `bc_last_i` changes only at segment boundaries, and the crossing number may then sit above the new limit, so the wrap-on-exceed case is exercised. Random accept bursts are mixed with a directed burst of 17 back-to-back accepts to reach a full store and its overflow.

// File: rtl/derand_pkg.sv
package derand_pkg;
    parameter int BC_W   = 12;
    parameter int EC_W   = 24;
    parameter int TYPE_W = 4;

    typedef struct packed {
        logic [BC_W-1:0]   bc;
        logic [EC_W-1:0]   ec;
        logic [TYPE_W-1:0] etype;
    } tag_t;
endpackage

// File: rtl/derand_counters.sv
module derand_counters
    import derand_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bc_clear_i,
    input  logic            ec_clear_i,
    input  logic            accept_i,
    input  logic [BC_W-1:0] bc_last_i,
    output logic [BC_W-1:0] bc_o,
    output logic [EC_W-1:0] ec_o
);
    typedef struct packed {
        logic [BC_W-1:0] bc;
        logic [EC_W-1:0] ec;
    } cnt_s;

    cnt_s state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (bc_clear_i || state_q.bc >= bc_last_i) state_d.bc = '0;
        else                                       state_d.bc = state_q.bc + 1'b1;
        if (ec_clear_i)    state_d.ec = '0;
        else if (accept_i) state_d.ec = state_q.ec + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bc_o = state_q.bc;
    assign ec_o = state_q.ec;

    // R2: ordinary crossing step
    a_r2_bc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!bc_clear_i && state_q.bc < bc_last_i) |=> state_q.bc == $past(state_q.bc) + 1'b1);
    // R3: every accept advances the event number
    a_r3_ec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !ec_clear_i) |=> state_q.ec == $past(state_q.ec) + 1'b1);
endmodule

// File: rtl/derand_store.sv
module derand_store
    import derand_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  tag_t             wtag_i,
    output tag_t             head_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        tag_t [DEPTH-1:0] slot;
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } store_s;

    store_s state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (push_i) begin
            state_d.slot[state_q.wr] = wtag_i;
            state_d.wr = (state_q.wr == LAST) ? '0 : state_q.wr + 1'b1;
        end
        if (pop_i) begin
            state_d.rd = (state_q.rd == LAST) ? '0 : state_q.rd + 1'b1;
        end
        case ({push_i, pop_i})
            2'b10:   state_d.cnt = state_q.cnt + 1'b1;
            2'b01:   state_d.cnt = state_q.cnt - 1'b1;
            default: state_d.cnt = state_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign head_o  = state_q.slot[state_q.rd];
    assign count_o = state_q.cnt;

    // R5: simultaneous store and pop leave the count alone
    a_r5_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> $stable(state_q.cnt));
    // R8: the sequencer never pops an empty store
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> state_q.cnt != '0);
    // R6: the top never pushes into a full store
    a_r6_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> state_q.cnt != FULL);
endmodule

// File: rtl/derand_seq.sv
module derand_seq #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] occ_i,
    input  logic             done_i,
    output logic             start_o,
    output logic             pop_o
);
    typedef struct packed {
        logic start;
        logic busy;
    } seq_s;

    seq_s state_d, state_q;

    always_comb begin
        state_d.start = (occ_i != '0) && !state_q.busy;
        state_d.busy  = state_d.start || (state_q.busy && !done_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign start_o = state_q.start;
    assign pop_o   = state_q.busy && done_i;

    // R7: start lasts exactly one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.start |=> !state_q.start);
    // R7: a start never refers to an empty store
    a_r7_start_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.start |-> occ_i != '0);
    // R8: done while idle does nothing to the link state
    a_r8_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.busy && occ_i == '0) |=> !state_q.busy);
endmodule

// File: rtl/trig_derand_mirror.sv
module trig_derand_mirror
    import derand_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l1_accept_i,
    input  logic [TYPE_W-1:0] evt_type_i,
    input  logic              bc_clear_i,
    input  logic              ec_clear_i,
    input  logic [BC_W-1:0]   bc_last_i,
    input  logic              fmt_done_i,
    output logic              fmt_start_o,
    output logic [BC_W-1:0]   head_bc_o,
    output logic [EC_W-1:0]   head_ec_o,
    output logic [TYPE_W-1:0] head_type_o,
    output logic [CNT_W-1:0]  occupancy_o,
    output logic              overflow_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [BC_W-1:0] bc_now;
    logic [EC_W-1:0] ec_now;
    logic            full, push, pop;
    tag_t            head, wtag;
    logic            ovf_d, ovf_q;

    derand_counters u_counters (
        .clk        (clk),
        .rst_n      (rst_n),
        .bc_clear_i (bc_clear_i),
        .ec_clear_i (ec_clear_i),
        .accept_i   (l1_accept_i),
        .bc_last_i  (bc_last_i),
        .bc_o       (bc_now),
        .ec_o       (ec_now)
    );

    assign full = (occupancy_o == FULL);
    assign push = l1_accept_i && !full;
    assign wtag = '{bc: bc_now, ec: ec_now, etype: evt_type_i};

    derand_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (pop),
        .wtag_i  (wtag),
        .head_o  (head),
        .count_o (occupancy_o)
    );

    derand_seq #(.CNT_W(CNT_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .occ_i   (occupancy_o),
        .done_i  (fmt_done_i),
        .start_o (fmt_start_o),
        .pop_o   (pop)
    );

    always_comb begin
        ovf_d = ovf_q || (l1_accept_i && full);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= ovf_d;
    end

    assign overflow_o  = ovf_q;
    assign head_bc_o   = head.bc;
    assign head_ec_o   = head.ec;
    assign head_type_o = head.etype;

    // R6: overflow stays set once raised
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);
    // R6: an accept on a full store raises overflow
    a_r6_flag_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_accept_i && occupancy_o == FULL) |=> overflow_o);
    // R5: occupancy never exceeds the depth
    a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy_o <= FULL);
endmodule

// File: tb/trig_derand_mirror_bench.sv
module trig_derand_mirror_bench;
    import derand_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              l1_accept_i = 1'b0;
    logic [TYPE_W-1:0] evt_type_i = '0;
    logic              bc_clear_i = 1'b0;
    logic              ec_clear_i = 1'b0;
    logic [BC_W-1:0]   bc_last_i = 12'd99;
    logic              fmt_done_i = 1'b0;
    logic              fmt_start_o;
    logic [BC_W-1:0]   head_bc_o;
    logic [EC_W-1:0]   head_ec_o;
    logic [TYPE_W-1:0] head_type_o;
    logic [4:0]        occupancy_o;
    logic              overflow_o;

    trig_derand_mirror u_trig_derand_mirror (.*);

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model, written from the requirements
    tag_t            m_q[$];
    logic [BC_W-1:0] m_bc;
    logic [EC_W-1:0] m_ec;
    logic            m_ovf, m_busy, m_start;
    int              fmt_cnt = 0;
    bit              spur_prev = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            m_bc = '0; m_ec = '0; m_ovf = 0; m_busy = 0; m_start = 0;
        end else begin
            bit full, push, pop, nstart;
            full   = (m_q.size() == 16);
            push   = l1_accept_i && !full;
            pop    = fmt_done_i && m_busy;
            nstart = (m_q.size() != 0) && !m_busy;
            if (pop)  void'(m_q.pop_front());
            if (push) m_q.push_back('{bc: m_bc, ec: m_ec, etype: evt_type_i});
            if (l1_accept_i && full) m_ovf = 1;
            if (ec_clear_i)       m_ec = '0;
            else if (l1_accept_i) m_ec = m_ec + 1'b1;
            if (bc_clear_i || m_bc >= bc_last_i) m_bc = '0;
            else                                 m_bc = m_bc + 1'b1;
            m_busy  = nstart || (m_busy && !fmt_done_i);
            m_start = nstart;
        end
    end

    task automatic chk(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compare at the falling edge, then drive the next inputs
    task automatic step(int acc_div, int spur_div, int bcc_div, int ecc_div);
        @(negedge clk);
        chk(spur_prev ? "R8" : "R5", "occupancy", occupancy_o, m_q.size());
        chk("R6", "overflow", overflow_o, m_ovf);
        chk("R7", "start", fmt_start_o, m_start);
        if (m_q.size() != 0) begin
            chk("R2", "head crossing", head_bc_o, m_q[0].bc);
            chk("R3", "head event", head_ec_o, m_q[0].ec);
            chk("R4", "head type", head_type_o, m_q[0].etype);
        end
        fmt_done_i = 1'b0;
        spur_prev  = 0;
        if (fmt_cnt != 0) begin
            fmt_cnt--;
            if (fmt_cnt == 0) fmt_done_i = 1'b1;
        end
        if (fmt_start_o) fmt_cnt = 35;
        else if (fmt_cnt == 0 && !m_busy && spur_div != 0 && ($urandom % spur_div) == 0) begin
            fmt_done_i = 1'b1;   // R8: stray done while idle
            spur_prev  = 1;
        end
        l1_accept_i = (acc_div != 0) && (($urandom % acc_div) == 0);
        evt_type_i  = TYPE_W'($urandom);
        bc_clear_i  = (bcc_div != 0) && (($urandom % bcc_div) == 0);
        ec_clear_i  = (ecc_div != 0) && (($urandom % ecc_div) == 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        l1_accept_i = 0; fmt_done_i = 0; bc_clear_i = 0; ec_clear_i = 0;
        fmt_cnt = 0; spur_prev = 0;
        repeat (2) @(negedge clk);
        chk("R1", "reset occupancy", occupancy_o, 0);
        chk("R1", "reset overflow", overflow_o, 0);
        chk("R1", "reset start", fmt_start_o, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd4711));
        do_reset();
        step(0, 0, 0, 0);
        chk("R1", "occupancy after release", occupancy_o, 0);
        // R6, R9: 17 back-to-back accepts fill the store and overflow it
        for (int i = 0; i < 17; i++) begin
            step(1, 0, 0, 0);
        end
        step(0, 0, 0, 0);
        chk("R6", "full occupancy", occupancy_o, 16);
        chk("R6", "overflow raised", overflow_o, 1);
        // drain, with stray dones while idle
        for (int i = 0; i < 800; i++) step(0, 8, 0, 0);
        chk("R6", "overflow still set after drain", overflow_o, 1);
        chk("R5", "drained occupancy", occupancy_o, 0);
        do_reset();
        step(0, 0, 0, 0);
        chk("R6", "overflow cleared by reset", overflow_o, 0);
        // random segments with varying wrap limits
        for (int seg = 0; seg < 10; seg++) begin
            bc_last_i = BC_W'(20 + ($urandom % 400));
            for (int i = 0; i < 2000; i++) begin
                if (($urandom % 400) == 0) begin
                    for (int b = 0; b < 6; b++) step(1, 0, 0, 0);
                end else begin
                    step(48, 16, 500, 1500);
                end
            end
        end
        for (int i = 0; i < 700; i++) step(0, 8, 0, 0);
        chk("R9", "final drain", occupancy_o, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule